// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block brings an SDRAM device out of power-up and then keeps it refreshed. When `enable` is raised, the block first waits a programmable stabilization period so that the supplies and the memory clock can settle. It then steps through a fixed power-up sequence, inserting a programmed number of idle cycles after each command: close all banks, then one auto-refresh, then program the mode register. When the sequence is finished it raises `ready` and starts a free-running refresh timer.

Each time the refresh timer expires, one refresh becomes owed. Owed refreshes are requested from the memory access arbiter with a request/grant handshake and are issued only when the arbiter grants. If the arbiter is busy with other traffic, up to four owed refreshes are kept. They are issued back to back, separated only by the row-cycle recovery, as soon as grant returns. A fifth missed refresh is dropped and sets a sticky loss flag. Dropping `enable` returns every part of the block to its off state.

Top module: `sdram_refresh_seq`

## Requirements
- R1: While `enable` is low, and in the cycle after it is sampled low, `cmd` is NOP (0), `ready`, `ref_req` and `pend_lost` are 0 and `pend_cnt` is 0.
- R2: If `enable` is first sampled high at the end of cycle N, `cmd` shows PRECHARGE ALL (1) in cycle N+1+`init_delay`, and NOP before that.
- R3: The power-up commands appear in the order PRECHARGE ALL (1), AUTO REFRESH (2), LOAD MODE (3). Each lasts one cycle. Each is followed by `rp_dly`, `rc_dly` and `mrd_dly` NOP cycles respectively, and every other cycle is NOP (0).
- R4: `ready` rises in the first cycle after the NOP cycles that follow LOAD MODE, and stays high while `enable` stays high.
- R5: With `ready` first high in cycle R, a refresh falls due at the end of cycles R+P-1, R+2P-1 and so on, where P is `refresh_period` and a value of 0 means 1024. `pend_cnt` counts owed refreshes.
- R6: `ref_req` is high when `ready` is high, `pend_cnt` is nonzero and no row-cycle recovery is running. In any cycle with both `ref_req` and `ref_grant` high, `cmd` is AUTO REFRESH (2) and `pend_cnt` drops by one at the next edge.
- R7: After an issued refresh, `ref_req` stays low for `rc_dly` cycles, so queued refreshes are issued `rc_dly`+1 cycles apart.
- R8: `pend_cnt` never exceeds 4. A refresh that falls due while 4 are owed and none is being issued is dropped and sets `pend_lost`, which stays set until `enable` drops.
- R9: When a refresh falls due in the same cycle that one is issued, `pend_cnt` is unchanged.
- R10: Dropping `enable` after initialization clears `ready`, `pend_cnt` and `pend_lost` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all delays are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Starts the power-up sequence; low returns to off |
| init_delay | input | 14 | Stabilization cycles before the first command |
| refresh_period | input | 10 | Cycles between refreshes (0 = 1024) |
| mrd_dly | input | 2 | NOP cycles after LOAD MODE |
| rc_dly | input | 3 | NOP cycles after an AUTO REFRESH |
| rp_dly | input | 3 | NOP cycles after PRECHARGE ALL |
| ref_grant | input | 1 | Arbiter grants the memory to the refresh |
| cmd | output | 2 | 0 NOP, 1 PRECHARGE ALL, 2 AUTO REFRESH, 3 LOAD MODE |
| ref_req | output | 1 | Refresh request to the arbiter |
| ready | output | 1 | Power-up done, refresh running |
| pend_cnt | output | 3 | Number of owed refreshes |
| pend_lost | output | 1 | Sticky: a refresh was dropped |

## Verification
The timer expiring and an owed refresh being granted can land on the same clock edge, so the owed count must see an increment and a decrement together. The bench builds two owed refreshes with grant held low and no row-cycle recovery. It then raises grant exactly one cycle before a due point. It judges the result by requiring three back-to-back AUTO REFRESH commands in consecutive cycles and an owed count still at two after the shared edge. A second collision, a due point against a full queue with grant low, is judged by the loss flag rising in the expected cycle.

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq #(
  parameter int DLY_W = 14,
  parameter int PER_W = 10,
  parameter int QMAX  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DLY_W-1:0] init_delay,
  input  logic [PER_W-1:0] refresh_period,
  input  logic [1:0]       mrd_dly,
  input  logic [2:0]       rc_dly,
  input  logic [2:0]       rp_dly,
  input  logic             ref_grant,
  output logic [1:0]       cmd,
  output logic             ref_req,
  output logic             ready,
  output logic [2:0]       pend_cnt,
  output logic             pend_lost
);
  localparam logic [1:0] C_NOP = 2'd0, C_PRE = 2'd1, C_REF = 2'd2, C_LMR = 2'd3;
  localparam int QW = $clog2(QMAX + 1);

  typedef enum logic [3:0] {
    S_OFF, S_STAB, S_PRE, S_WRP, S_AR, S_WRC, S_LMR, S_WMR, S_RUN
  } st_t;

  st_t              st;
  logic [DLY_W-1:0] cnt;
  logic [PER_W-1:0] tmr;
  logic [2:0]       rcw;
  logic [QW-1:0]    pend;
  logic             due, issue;

  assign ready    = (st == S_RUN);
  assign due      = ready && (tmr == refresh_period - PER_W'(1));
  assign ref_req  = ready && (pend != '0) && (rcw == '0);
  assign issue    = ref_req && ref_grant;
  assign pend_cnt = 3'(pend);

  always_comb begin
    case (st)
      S_PRE:   cmd = C_PRE;
      S_AR:    cmd = C_REF;
      S_LMR:   cmd = C_LMR;
      default: cmd = issue ? C_REF : C_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF; cnt <= '0; tmr <= '0; rcw <= '0; pend <= '0; pend_lost <= 1'b0;
    end else if (!enable) begin
      st <= S_OFF; cnt <= '0; tmr <= '0; rcw <= '0; pend <= '0; pend_lost <= 1'b0;
    end else begin
      case (st)
        S_OFF:  begin cnt <= init_delay; st <= (init_delay == '0) ? S_PRE : S_STAB; end
        S_STAB: if (cnt == DLY_W'(1)) st <= S_PRE; else cnt <= cnt - 1'b1;
        S_PRE:  begin cnt <= DLY_W'(rp_dly); st <= (rp_dly == '0) ? S_AR : S_WRP; end
        S_WRP:  if (cnt == DLY_W'(1)) st <= S_AR; else cnt <= cnt - 1'b1;
        S_AR:   begin cnt <= DLY_W'(rc_dly); st <= (rc_dly == '0) ? S_LMR : S_WRC; end
        S_WRC:  if (cnt == DLY_W'(1)) st <= S_LMR; else cnt <= cnt - 1'b1;
        S_LMR:  begin cnt <= DLY_W'(mrd_dly); st <= (mrd_dly == '0) ? S_RUN : S_WMR; end
        S_WMR:  if (cnt == DLY_W'(1)) st <= S_RUN; else cnt <= cnt - 1'b1;
        default: st <= S_RUN;
      endcase

      tmr <= (!ready || due) ? '0 : tmr + 1'b1;

      if (issue) rcw <= rc_dly;
      else if (rcw != '0) rcw <= rcw - 1'b1;

      if (due && !issue) begin
        if (pend == QW'(QMAX)) pend_lost <= 1'b1;
        else pend <= pend + 1'b1;
      end else if (!due && issue) begin
        pend <= pend - 1'b1;
      end
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cmd == C_NOP && !ready && !ref_req && pend_cnt == 3'd0 && !pend_lost)); // R1
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && enable) |=> ready); // R4
  AST_REF_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cmd == C_REF) |-> ref_grant); // R6
  AST_RC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && rc_dly != 3'd0) |=> !ref_req); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= 3'(QMAX)); // R8
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_lost && enable) |=> pend_lost); // R8
  AST_DUE_AND_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (due && issue && enable) |=> pend_cnt == $past(pend_cnt)); // R9
endmodule

// File: tb/sdram_refresh_seq_test.sv
`timescale 1ns/1ps
module sdram_refresh_seq_test;
  logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b0, ref_grant = 1'b1;
  logic [13:0] init_delay = 14'd20;
  logic [9:0]  refresh_period = 10'd30;
  logic [1:0]  mrd_dly = 2'd1;
  logic [2:0]  rc_dly = 3'd3, rp_dly = 3'd2;
  logic [1:0]  cmd;
  logic        ref_req, ready, pend_lost;
  logic [2:0]  pend_cnt;

  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 0;
  int exp_cyc[$];
  int exp_cmd[$];
  string exp_tag[$];

  sdram_refresh_seq uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .init_delay(init_delay),
    .refresh_period(refresh_period), .mrd_dly(mrd_dly), .rc_dly(rc_dly),
    .rp_dly(rp_dly), .ref_grant(ref_grant), .cmd(cmd), .ref_req(ref_req),
    .ready(ready), .pend_cnt(pend_cnt), .pend_lost(pend_lost)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, expv);
    end
  endtask

  task automatic expect_cmd(input int c, input int k, input string tag);
    exp_cyc.push_back(c); exp_cmd.push_back(k); exp_tag.push_back(tag);
  endtask

  task automatic go(input int n);
    while (cyc < n) begin @(posedge clk); #1; end
  endtask

  task automatic look(input int n);
    go(n); @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && cmd != 2'd0) begin
      if (exp_cyc.size() == 0) begin
        chk(0, "R3 unexpected command", int'(cmd), 0);
      end else begin
        int ec, ek;
        string et;
        ec = exp_cyc.pop_front(); ek = exp_cmd.pop_front(); et = exp_tag.pop_front();
        chk(ec == cyc, {et, " cycle"}, cyc, ec);
        chk(ek == int'(cmd), {et, " code"}, int'(cmd), ek);
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    go(3); rst_n = 1'b1;
    look(4);
    chk(cmd == 2'd0 && !ready && !ref_req && pend_cnt == 0 && !pend_lost, "R1 off state", int'(cmd), 0);

    // phase 1: D=20 rp=2 rc=3 mrd=1 P=30, enable during cycle 5
    expect_cmd(26, 1, "R2 precharge");
    expect_cmd(29, 2, "R3 init refresh");
    expect_cmd(33, 3, "R3 load mode");
    expect_cmd(65, 2, "R5 first refresh");
    expect_cmd(95, 2, "R5 second refresh");
    expect_cmd(250, 2, "R7 queued 1");
    expect_cmd(254, 2, "R7 queued 2");
    expect_cmd(258, 2, "R7 queued 3");
    expect_cmd(262, 2, "R7 queued 4");
    expect_cmd(275, 2, "R5 after drain");
    go(5); enable = 1'b1;
    look(34); chk(!ready, "R4 ready early", int'(ready), 0);
    look(35); chk(ready, "R4 ready rises", int'(ready), 1);
    look(64); chk(pend_cnt == 0 && !ref_req, "R5 nothing owed before due", int'(pend_cnt), 0);
    go(96); ref_grant = 1'b0;
    look(125); chk(pend_cnt == 1 && ref_req, "R6 request while owed", int'(pend_cnt), 1);
    look(216); chk(pend_cnt == 4 && !pend_lost, "R8 queue full", int'(pend_cnt), 4);
    look(244); chk(!pend_lost, "R8 no loss yet", int'(pend_lost), 0);
    look(245); chk(pend_lost && pend_cnt == 4, "R8 loss flag", int'(pend_lost), 1);
    go(250); ref_grant = 1'b1;
    look(251); chk(!ref_req && pend_cnt == 3, "R7 recovery blocks request", int'(ref_req), 0);
    look(253); chk(!ref_req, "R7 recovery last cycle", int'(ref_req), 0);
    look(254); chk(ref_req, "R7 request back", int'(ref_req), 1);
    look(270); chk(pend_lost, "R8 loss sticky", int'(pend_lost), 1);
    go(280); enable = 1'b0;
    look(281);
    chk(!ready && pend_cnt == 0 && !pend_lost && !ref_req, "R10 disable clears", int'(pend_lost), 0);
    look(283); chk(cmd == 2'd0, "R1 disabled NOP", int'(cmd), 0);

    // phase 2: D=5 rp=0 rc=0 mrd=0 P=10, enable during cycle 285
    init_delay = 14'd5; rp_dly = 3'd0; rc_dly = 3'd0; mrd_dly = 2'd0;
    refresh_period = 10'd10; ref_grant = 1'b0;
    expect_cmd(291, 1, "R2 precharge zero waits");
    expect_cmd(292, 2, "R3 refresh zero waits");
    expect_cmd(293, 3, "R3 load mode zero waits");
    expect_cmd(323, 2, "R9 collision 1");
    expect_cmd(324, 2, "R9 collision 2");
    expect_cmd(325, 2, "R9 collision 3");
    expect_cmd(334, 2, "R5 next due");
    go(285); enable = 1'b1;
    look(294); chk(ready, "R4 ready zero waits", int'(ready), 1);
    look(314); chk(pend_cnt == 2, "R5 two owed", int'(pend_cnt), 2);
    go(323); ref_grant = 1'b1;
    look(324); chk(pend_cnt == 2, "R9 due and issue same edge", int'(pend_cnt), 2);
    look(326); chk(pend_cnt == 0, "R6 drained", int'(pend_cnt), 0);
    look(340);
    chk(exp_cyc.size() == 0, "R3 missing commands", exp_cyc.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule